// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block is a watchdog that counts ticks of a slow oscillator through a binary prescaler and raises a one-clock reset request when the selected count elapses without a restart. Software restarts it through a kick input. A small control register holds an enable bit, a change-enable bit and a four-bit period code, written and read through a plain synchronous register port.

A static safety-level input chooses how much of that register is protected. In the relaxed level the watchdog comes out of reset stopped and any write may start it, but stopping it again needs a two-step unlock. In the strict level it runs from reset, can never be stopped, and only the period code is guarded. The unlock is a write carrying change-enable and enable together. It opens a short window in which one write with change-enable clear is taken as the real change. The window closes by itself after a fixed number of system clocks.

The period code n selects a timeout of 2^(BASE_EXP+n) slow ticks for n up to CODE_MAX. Larger codes behave as CODE_MAX. The register port and the kick are control pins with no back-pressure: each write is taken in the cycle it is presented.

Top module: `wdg_guard`

## Requirements
- R1: After reset the read value has period code 0 and change-enable 0, the reset request is low, and the enable bit reads 0 in level 1 and 1 in level 2. Read layout: bit 0 enable, bit 1 change-enable (high while the window is open), bits 5:2 period code.
- R2: In level 1, any write with bit 0 set turns a stopped watchdog on, without an unlock.
- R3: In level 1, a write that clears the enable bit takes effect only inside an open window. Outside a window the running watchdog keeps running.
- R4: A window opens only on a write with bit 1 and bit 0 both set. A write with bit 1 set and bit 0 clear opens nothing.
- R5: With WIN_CLKS=4, a write with bit 1 clear is taken as a change when it comes 1 to 4 clocks after the unlock write, and as an ordinary write when it comes 5 or more clocks later. Bit 1 reads 1 while the window is open.
- R6: Outside an open window, writes never change the period code, in either level.
- R7: In level 2 the enable bit always reads 1. An accepted change updates the period code only, and the enable bit written with it is ignored.
- R8: With code n, the reset request rises the clock after the 2^(BASE_EXP+min(n,CODE_MAX))-th tick counted since the last restart. It is high for exactly one clock, and counting restarts from zero.
- R9: Only cycles with the tick input high are counted. A kick, or an accepted change, restarts the count from zero.
- R10: While the watchdog is stopped, the reset request stays low whatever the tick input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl2_i | input | 1 | Safety level: 0 relaxed, 1 strict; held static |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 6 | Write data: bit 0 enable, bit 1 change-enable, bits 5:2 period code |
| cfg_rdata_o | output | 6 | Read value, same layout |
| tick_i | input | 1 | Slow-oscillator tick enable, one cycle per tick |
| kick_i | input | 1 | Restart the count |
| rst_req_o | output | 1 | One-clock reset request on timeout |

## Verification
The hardest case to reach is the exact edge of the unlock window. That is a second write landing on the fourth clock after the unlock, where it must be taken, or on the fifth, where it must be treated as an ordinary write. The stimulus places the second write a known number of idle cycles after the unlock. Directed cases cover both edges, and a seeded random loop picks gaps from 1 to 6 with random data. A bench model predicts the read-back from the gap alone. Timeouts are measured for every valid period code under continuous and randomly gated ticks, using a small BASE_EXP so that the longest period stays short.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int PER_W = 4;

  typedef struct packed {
    logic [PER_W-1:0] per;
    logic             chg;
    logic             en;
  } wdg_ctrl_t;

  localparam int CTRL_W = $bits(wdg_ctrl_t);
endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
  import wdg_pkg::*;
#(
  parameter int WIN_CLKS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  wdg_ctrl_t wdata,
  output logic      win_open
);
  localparam int CW = $clog2(WIN_CLKS + 1);

  logic [CW-1:0] left_q;
  logic          unlock_wr;

  assign unlock_wr = wr && wdata.chg && wdata.en;
  assign win_open  = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (unlock_wr) begin
      left_q <= CW'(WIN_CLKS);
    end else if (wr && win_open && !wdata.chg) begin
      left_q <= '0;
    end else if (win_open) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl2,
  input  logic             wr,
  input  wdg_ctrl_t        wdata,
  input  logic             win_open,
  output logic             en_eff,
  output logic [PER_W-1:0] per,
  output logic             restart
);
  logic             en_q;
  logic [PER_W-1:0] per_q;
  logic             accept;
  logic             turn_on;

  assign accept  = wr && win_open && !wdata.chg;
  assign en_eff  = lvl2 || en_q;
  assign turn_on = wr && wdata.en && !en_eff;
  assign restart = accept || turn_on;
  assign per     = per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      per_q <= '0;
    end else if (accept) begin
      per_q <= wdata.per;
      if (!lvl2) en_q <= wdata.en;
    end else if (wr && wdata.en) begin
      en_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int CODE_MAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             clear,
  input  logic [PER_W-1:0] code,
  output logic             req
);
  localparam int CNT_W = BASE_EXP + CODE_MAX + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [PER_W-1:0] code_eff;
  logic [CNT_W-1:0] last;

  always_comb begin
    code_eff = (code > PER_W'(CODE_MAX)) ? PER_W'(CODE_MAX) : code;
    last     = (CNT_W'(1) << (BASE_EXP + int'(code_eff))) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      req <= 1'b0;
      if (clear || !en) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == last) begin
          cnt_q <= '0;
          req   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int CODE_MAX = 9,
  parameter int WIN_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl2_i,
  input  logic              cfg_wr_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  input  logic              tick_i,
  input  logic              kick_i,
  output logic              rst_req_o
);
  wdg_ctrl_t        wdata;
  wdg_ctrl_t        rview;
  logic             win_open;
  logic             en_eff;
  logic [PER_W-1:0] per;
  logic             restart;

  assign wdata = wdg_ctrl_t'(cfg_wdata_i);

  wdg_unlock #(.WIN_CLKS(WIN_CLKS)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr_i), .wdata(wdata), .win_open(win_open)
  );

  wdg_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .lvl2(lvl2_i), .wr(cfg_wr_i), .wdata(wdata),
    .win_open(win_open), .en_eff(en_eff), .per(per), .restart(restart)
  );

  wdg_prescaler #(.BASE_EXP(BASE_EXP), .CODE_MAX(CODE_MAX)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en_eff), .tick(tick_i),
    .clear(kick_i || restart), .code(per), .req(rst_req_o)
  );

  always_comb begin
    rview.per   = per;
    rview.chg   = win_open;
    rview.en    = en_eff;
    cfg_rdata_o = rview;
  end
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
  parameter int WIN_CLKS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lvl2_i,
  input logic       cfg_wr_i,
  input logic [5:0] cfg_wdata_i,
  input logic [5:0] cfg_rdata_o,
  input logic       kick_i,
  input logic       rst_req_o
);
  localparam int RW = $clog2(WIN_CLKS + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (cfg_wr_i && cfg_wdata_i[1] && cfg_wdata_i[0]) run_q <= '0;
    else if (cfg_rdata_o[1]) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  p_win_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(WIN_CLKS));

  p_lvl2_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl2_i |-> cfg_rdata_o[0]);

  p_no_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl2_i && cfg_rdata_o[0] && !cfg_rdata_o[1]) |=> cfg_rdata_o[0]);

  p_per_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata_o[1] |=> $stable(cfg_rdata_o[5:2]));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_kick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !rst_req_o);

  p_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata_o[0] |=> !rst_req_o);
endmodule

bind wdg_guard wdg_guard_chk #(.WIN_CLKS(WIN_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl2_i(lvl2_i), .cfg_wr_i(cfg_wr_i),
  .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
  .kick_i(kick_i), .rst_req_o(rst_req_o)
);

// File: tb/wdg_guard_bench.sv
module wdg_guard_bench;
  localparam int BE = 2;
  localparam int CM = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lvl2_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic [5:0] cfg_wdata_i = '0;
  logic [5:0] cfg_rdata_o;
  logic       tick_i = 1'b0;
  logic       kick_i = 1'b0;
  logic       rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdg_guard #(.BASE_EXP(BE), .CODE_MAX(CM), .WIN_CLKS(4)) u_wdg_guard (
    .clk(clk), .rst_n(rst_n), .lvl2_i(lvl2_i), .cfg_wr_i(cfg_wr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .tick_i(tick_i), .kick_i(kick_i), .rst_req_o(rst_req_o)
  );

  function automatic int exp_ticks(input int code);
    return 1 << (BE + ((code > CM) ? CM : code));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [5:0] d);
    cfg_wr_i = 1'b1;
    cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    cfg_wdata_i = '0;
  endtask

  task automatic do_reset(input bit lvl);
    lvl2_i = lvl;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic measure(input string tag, input int exp, input bit rnd);
    int ticks = 0;
    bit seen = 0;
    kick_i = 1'b1;
    idle(1);
    kick_i = 1'b0;
    for (int i = 0; i < exp * 4 + 16; i++) begin
      tick_i = rnd ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
      if (tick_i) ticks++;
      if (rst_req_o) begin
        seen = 1;
        break;
      end
    end
    tick_i = 1'b0;
    chk({tag, " timeout seen"}, int'(seen), 1);
    chk({tag, " tick count"}, ticks, exp);
    idle(1);
    chk({tag, " one-cycle pulse"}, int'(rst_req_o), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] d;
    logic [3:0] m_per;
    int g;
    bit seen;
    void'($urandom(32'd4242));
    idle(2);

    // level 1
    do_reset(1'b0);
    chk("R1 reset rdata lvl1", int'(cfg_rdata_o), 'h00);
    chk("R1 reset req", int'(rst_req_o), 0);
    wr_cfg(6'h3C);
    chk("R6 period ignored outside window", int'(cfg_rdata_o), 'h00);
    wr_cfg(6'h01);
    chk("R2 ordinary enable", int'(cfg_rdata_o), 'h01);
    wr_cfg(6'h00);
    chk("R3 disable outside window ignored", int'(cfg_rdata_o), 'h01);
    wr_cfg(6'h02);
    chk("R4 chg without en opens nothing", int'(cfg_rdata_o), 'h01);
    wr_cfg(6'h00);
    chk("R4 follow-up rejected", int'(cfg_rdata_o), 'h01);
    wr_cfg(6'h03);
    chk("R5 window open readback", int'(cfg_rdata_o), 'h03);
    wr_cfg(6'h0D);
    chk("R5 change on clock 1 accepted", int'(cfg_rdata_o), 'h0D);
    measure("R8 lvl1 code3", exp_ticks(3), 1'b0);
    wr_cfg(6'h03);
    idle(3);
    wr_cfg(6'h00);
    chk("R3 R5 disable on clock 4 accepted", int'(cfg_rdata_o), 'h00);

    seen = 0;
    tick_i = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rst_req_o) seen = 1;
    end
    tick_i = 1'b0;
    chk("R10 stopped never requests", int'(seen), 0);

    wr_cfg(6'h01);
    wr_cfg(6'h03);
    idle(4);
    wr_cfg(6'h08);
    chk("R5 change on clock 5 rejected", int'(cfg_rdata_o), 'h01);

    m_per = 4'd0;
    for (int k = 0; k < 30; k++) begin
      d = 6'($urandom) & 6'h3D;
      g = 1 + int'($urandom % 6);
      wr_cfg(6'h03);
      idle(g - 1);
      wr_cfg(d);
      if (g <= 4) begin
        chk("R5 random accepted gap", int'(cfg_rdata_o), int'({d[5:2], 1'b0, d[0]}));
        m_per = d[5:2];
      end else begin
        chk("R5 R6 random rejected gap", int'(cfg_rdata_o), int'({m_per, 2'b01}));
      end
      idle(5);
    end

    // level 2
    do_reset(1'b1);
    chk("R1 reset rdata lvl2", int'(cfg_rdata_o), 'h01);
    wr_cfg(6'h00);
    chk("R7 en stays one", int'(cfg_rdata_o), 'h01);
    wr_cfg(6'h14);
    chk("R6 lvl2 period ignored outside window", int'(cfg_rdata_o), 'h01);
    for (int n = 0; n <= 12; n++) begin
      if (n == 10 || n == 11) continue;
      wr_cfg(6'h03);
      wr_cfg({4'(n), 2'b00});
      chk("R7 lvl2 change keeps en", int'(cfg_rdata_o), int'({4'(n), 2'b01}));
      measure("R8 lvl2 period", exp_ticks(n), n[0]);
    end

    wr_cfg(6'h03);
    wr_cfg(6'h00);
    seen = 0;
    kick_i = 1'b1;
    idle(1);
    kick_i = 1'b0;
    tick_i = 1'b1;
    idle(3);
    kick_i = 1'b1;
    idle(1);
    kick_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (rst_req_o) seen = 1;
    end
    tick_i = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rst_req_o) seen = 1;
    end
    chk("R9 kick restarts and idle ticks not counted", int'(seen), 0);
    measure("R9 R8 after kick", exp_ticks(0), 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule